// File: doc/BRIEF.md
# ECC Memory Controller Register Bank

This block is the control and status register file of an ECC memory controller. Software reaches nine 32-bit word registers: enable, delay, fault status, video configuration, two fault address words, a diagnostic word and two event counters. Registers are selected by request address bits [5:2]. A build-time parameter picks one of three controller variants. The variant decides which enable-register bits can be written, which identification value reads back, and which fields survive a soft reset. Variant 0 also gets a separate four-byte window that is accessed one byte at a time.

Requests arrive on a valid/ready channel. The block accepts a request in any cycle where `req_valid` and `req_ready` are both high. A read returns its data on a response channel one cycle after it is accepted. The response is held stable until `rsp_ready` takes it. While an untaken response is waiting, `req_ready` stays low, so a new request cannot overrun it.

A fault-inject port lets a test or a neighbouring checker place an error record into the fault status register. The level interrupt `irq` rises when the record shows an uncorrectable error, or a correctable error while correctable-error interrupts are enabled. Any bus write to fault status lowers `irq`.

Top module: `ecc_regbank`

## Requirements
- R1: An enable-register write (word offset 0) keeps only the data bits in 0x0000_0103 for variant 0, and that variant reads its top byte as zero. For variants 1 and 2 it keeps the data bits in 0x0000_0BFF, and the read value also carries the variant number in bits 31:28 with zero in bits 27:24. Bit 0 is ECC check enable and bit 1 is correctable-error interrupt enable.
- R2: A write to the delay register (offset 1) stores the data with bit 31 forced to zero.
- R3: A write to fault status (offset 2) stores all 32 written bits and drives `irq` low from the next cycle.
- R4: Writes to the two fault address registers (offsets 4 and 5) leave them unchanged.
- R5: Soft reset (`soft_rst`) keeps only enable bit 8 for variant 0. For variants 1 and 2 it keeps bits 31:24, 11 and 9:2 of the enable register.
- R6: After power-on reset or soft reset, the registers read delay 0x20, fault address 0 0x07C0_0000, and zero for fault status, video, fault address 1, diagnostic and both event counters, with `irq` low. After power-on reset, the enable register reads only its identification field.
- R7: For variant 0, byte requests (`req_diag`=1, `req_word`=0) write and read one of four bytes selected by address bits [1:0], returned in bits 7:0 of the response. All four bytes are zero after power-on reset. For other variants these requests read zero and store nothing.
- R8: A fault-inject pulse loads fault status with `fault_info` AND 0x0001_FFF9. The fields are bit 0 correctable, bit 3 uncorrectable, bits 7:4 double-word index, bits 15:8 syndrome and bit 16 multiple errors. It raises `irq` if bit 3 is set, or if bit 0 is set while enable bit 1 is set. Otherwise `irq` keeps its value.
- R9: When a fault-inject pulse and a fault status write fall in the same cycle, the injected record is stored and `irq` follows the inject rule.
- R10: Event counters 0 and 1 (offsets 7 and 8) hold separate values. Offsets 9 to 15 read zero and ignore writes.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` stays unchanged.
- R12: Main-window requests that are not full-word (`req_word`=0, `req_diag`=0) store nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset that keeps selected enable fields |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_diag | input | 1 | 1 = byte diagnostic window, 0 = main register window |
| req_word | input | 1 | 1 = full 32-bit access, 0 = byte access |
| req_addr | input | ADDR_W | Byte address; [5:2] register index, [1:0] byte index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Response taken when high together with rsp_valid |
| rsp_rdata | output | 32 | Read data |
| fault_valid | input | 1 | One-cycle fault-inject strobe |
| fault_info | input | 32 | Fault record to latch into fault status |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can land on the fault status register in the same cycle: a bus write and a fault-inject pulse. The bench drives both on the same falling edge. It sends an uncorrectable record together with a write of zero. It then reads fault status back and samples `irq`, and expects the injected record with `irq` high. A second case uses a correctable record with interrupts disabled and `irq` already low. There the write must still lose to the record, and `irq` must stay low.

// File: rtl/ecc_regbank_pkg.sv
package ecc_regbank_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned EVCNT_N = 2;

  localparam logic [IDX_W-1:0] IDX_ENABLE = 4'd0;
  localparam logic [IDX_W-1:0] IDX_DELAY  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_FSTAT  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_VIDEO  = 4'd3;
  localparam logic [IDX_W-1:0] IDX_FADDR0 = 4'd4;
  localparam logic [IDX_W-1:0] IDX_FADDR1 = 4'd5;
  localparam logic [IDX_W-1:0] IDX_DIAG   = 4'd6;
  localparam logic [IDX_W-1:0] IDX_EVCNT0 = 4'd7;
  localparam logic [IDX_W-1:0] IDX_EVCNT1 = 4'd8;

  localparam logic [DATA_W-1:0] DELAY_WMASK    = 32'h7FFF_FFFF;
  localparam logic [DATA_W-1:0] DELAY_RST      = 32'h0000_0020;
  localparam logic [DATA_W-1:0] FADDR0_RST     = 32'h07C0_0000;
  localparam logic [DATA_W-1:0] FSTAT_INJ_MASK = 32'h0001_FFF9;

  localparam int unsigned FS_CE  = 0;
  localparam int unsigned FS_UE  = 3;
  localparam int unsigned EN_IE  = 1;

  // identification value merged into the enable register (impl nibble)
  function automatic logic [DATA_W-1:0] variant_id(int unsigned v);
    return {4'(v), 28'h0};
  endfunction

  function automatic logic [DATA_W-1:0] enable_wmask(int unsigned v);
    return (v == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [DATA_W-1:0] enable_keep(int unsigned v);
    return (v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction

endpackage

// File: rtl/ecc_bus_port.sv
module ecc_bus_port
  import ecc_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_diag,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              main_we,
  output logic [IDX_W-1:0]  main_idx,
  input  logic [DATA_W-1:0] main_rdata,
  output logic              diag_we,
  output logic [SEL_W-1:0]  diag_sel,
  input  logic [7:0]        diag_rdata
);

  logic              accept;
  logic              main_hit;
  logic              diag_hit;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [DATA_W-1:0] rd_value;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign main_hit  = !req_diag && req_word;
  assign diag_hit  = req_diag && !req_word;
  assign main_idx  = req_addr[SEL_W +: IDX_W];
  assign diag_sel  = req_addr[SEL_W-1:0];
  assign main_we   = accept && req_write && main_hit;
  assign diag_we   = accept && req_write && diag_hit;

  always_comb begin
    rd_value = '0;
    if (main_hit)      rd_value = main_rdata;
    else if (diag_hit) rd_value = {{(DATA_W-8){1'b0}}, diag_rdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  // R11: a stalled response keeps its data
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready) |=> (rsp_valid_q && $stable(rsp_data_q)));

endmodule

// File: rtl/ecc_diag_window.sv
module ecc_diag_window #(
  parameter int unsigned VARIANT = 0,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned BYTE_W  = 8,
  localparam int unsigned SEL_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  generate
    if (VARIANT == 0) begin : g_present
      logic [BYTE_W-1:0] bytes_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) bytes_q[i] <= '0;
        end else if (we) begin
          bytes_q[sel] <= wdata;
        end
      end

      assign rdata = bytes_q[sel];
    end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk, rst_n, we, sel, wdata};
      assign rdata     = '0;
    end
  endgenerate

endmodule

// File: rtl/ecc_reg_file.sv
module ecc_reg_file
  import ecc_regbank_pkg::*;
#(
  parameter int unsigned VARIANT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fault_valid,
  input  logic [DATA_W-1:0] fault_info,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam logic [DATA_W-1:0] ID_VALUE  = (VARIANT == 0) ? '0 : variant_id(VARIANT);
  localparam logic [DATA_W-1:0] EN_WMASK  = enable_wmask(VARIANT);
  localparam logic [DATA_W-1:0] EN_KEEP   = enable_keep(VARIANT);

  logic [DATA_W-1:0] enable_q;
  logic [DATA_W-1:0] delay_q;
  logic [DATA_W-1:0] fstat_q;
  logic [DATA_W-1:0] video_q;
  logic [DATA_W-1:0] faddr0_q;
  logic [DATA_W-1:0] faddr1_q;
  logic [DATA_W-1:0] dreg_q;
  logic [DATA_W-1:0] evcnt_q [EVCNT_N];
  logic              irq_q;
  logic              fstat_wr;
  logic              inj_irq;

  assign fstat_wr = we && (idx == IDX_FSTAT);
  assign inj_irq  = fault_info[FS_UE] || (fault_info[FS_CE] && enable_q[EN_IE]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= ID_VALUE;
      delay_q  <= DELAY_RST;
      fstat_q  <= '0;
      video_q  <= '0;
      faddr0_q <= FADDR0_RST;
      faddr1_q <= '0;
      dreg_q   <= '0;
      for (int i = 0; i < EVCNT_N; i++) evcnt_q[i] <= '0;
      irq_q    <= 1'b0;
    end else if (soft_rst) begin
      enable_q <= enable_q & EN_KEEP;
      delay_q  <= DELAY_RST;
      fstat_q  <= '0;
      video_q  <= '0;
      faddr0_q <= FADDR0_RST;
      faddr1_q <= '0;
      dreg_q   <= '0;
      for (int i = 0; i < EVCNT_N; i++) evcnt_q[i] <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (we) begin
        case (idx)
          IDX_ENABLE: enable_q   <= ID_VALUE | (wdata & EN_WMASK);
          IDX_DELAY:  delay_q    <= wdata & DELAY_WMASK;
          IDX_FSTAT:  fstat_q    <= wdata;
          IDX_VIDEO:  video_q    <= wdata;
          IDX_DIAG:   dreg_q     <= wdata;
          IDX_EVCNT0: evcnt_q[0] <= wdata;
          IDX_EVCNT1: evcnt_q[1] <= wdata;
          default: ;
        endcase
      end
      if (fstat_wr) irq_q <= 1'b0;
      // inject is applied last so it wins over a same-cycle status write
      if (fault_valid) begin
        fstat_q <= fault_info & FSTAT_INJ_MASK;
        if (inj_irq) irq_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (idx)
      IDX_ENABLE: rdata = enable_q;
      IDX_DELAY:  rdata = delay_q;
      IDX_FSTAT:  rdata = fstat_q;
      IDX_VIDEO:  rdata = video_q;
      IDX_FADDR0: rdata = faddr0_q;
      IDX_FADDR1: rdata = faddr1_q;
      IDX_DIAG:   rdata = dreg_q;
      IDX_EVCNT0: rdata = evcnt_q[0];
      IDX_EVCNT1: rdata = evcnt_q[1];
      default:    rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R3: status write without inject lowers the interrupt
  a_r3_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat_wr && !fault_valid && !soft_rst) |=> !irq);

  // R8: uncorrectable record always raises the interrupt
  a_r8_ue_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_info[FS_UE] && !soft_rst) |=> irq);

  // R9: inject beats a same-cycle status write
  a_r9_inject_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fstat_wr && !soft_rst) |=> (fstat_q == $past(fault_info & FSTAT_INJ_MASK)));

  // R6: soft reset restores defaults
  a_r6_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (delay_q == DELAY_RST && fstat_q == '0 && !irq));

endmodule

// File: rtl/ecc_regbank.sv
module ecc_regbank
  import ecc_regbank_pkg::*;
#(
  parameter int unsigned VARIANT    = 1,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DIAG_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_diag,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  input  logic              fault_valid,
  input  logic [31:0]       fault_info,
  output logic              irq
);

  localparam int unsigned SEL_W = $clog2(DIAG_DEPTH);

  logic              main_we;
  logic [IDX_W-1:0]  main_idx;
  logic [DATA_W-1:0] main_rdata;
  logic              diag_we;
  logic [SEL_W-1:0]  diag_sel;
  logic [7:0]        diag_rdata;

  ecc_bus_port #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_diag   (req_diag),
    .req_word   (req_word),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .main_we    (main_we),
    .main_idx   (main_idx),
    .main_rdata (main_rdata),
    .diag_we    (diag_we),
    .diag_sel   (diag_sel),
    .diag_rdata (diag_rdata)
  );

  ecc_reg_file #(.VARIANT(VARIANT)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .we          (main_we),
    .idx         (main_idx),
    .wdata       (req_wdata),
    .fault_valid (fault_valid),
    .fault_info  (fault_info),
    .rdata       (main_rdata),
    .irq         (irq)
  );

  ecc_diag_window #(.VARIANT(VARIANT), .DEPTH(DIAG_DEPTH), .BYTE_W(8)) u_diag (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (diag_we),
    .sel   (diag_sel),
    .wdata (req_wdata[7:0]),
    .rdata (diag_rdata)
  );

endmodule

// File: tb/tb_ecc_regbank.sv
module tb_ecc_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_diag = 1'b0;
  logic        req_word = 1'b1;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        fault_valid = 1'b0;
  logic [31:0] fault_info = '0;

  logic        req_ready, req_ready_v0;
  logic        rsp_valid, rsp_valid_v0;
  logic [31:0] rsp_rdata, rsp_rdata_v0;
  logic        irq, irq_v0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;  // 125 MHz

  ecc_regbank #(.VARIANT(1)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_diag(req_diag), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .fault_valid(fault_valid), .fault_info(fault_info),
    .irq(irq));

  ecc_regbank #(.VARIANT(0)) dut_v0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .req_valid(req_valid), .req_ready(req_ready_v0), .req_write(req_write),
    .req_diag(req_diag), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid_v0), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata_v0), .fault_valid(fault_valid), .fault_info(fault_info),
    .irq(irq_v0));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input bit dg, input bit wd,
                     input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_diag = dg; req_word = wd;
    req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_reg(input int idx, input logic [31:0] d);
    bus(1'b1, 1'b0, 1'b1, 6'(idx * 4), d);
  endtask

  // expected (variant 1, variant 0)
  task automatic rd_reg(input int idx, input logic [31:0] e1, input logic [31:0] e0,
                        input string tag);
    exp_q.push_back({e1, e0});
    tag_q.push_back(tag);
    bus(1'b0, 1'b0, 1'b1, 6'(idx * 4), '0);
  endtask

  task automatic inject(input logic [31:0] info, input bit with_fstat_wr,
                        input logic [31:0] wdata);
    @(negedge clk);
    fault_valid = 1'b1; fault_info = info;
    if (with_fstat_wr) begin
      req_valid = 1'b1; req_write = 1'b1; req_diag = 1'b0; req_word = 1'b1;
      req_addr = 6'd8; req_wdata = wdata;
    end
    @(negedge clk);
    fault_valid = 1'b0; req_valid = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rsp_valid && rsp_ready) begin
        check("R11 both variants respond together", {31'd0, rsp_valid_v0}, 32'd1);
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({t, " v1"}, rsp_rdata, e[63:32]);
          check({t, " v0"}, rsp_rdata_v0, e[31:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 power-on values
    check("R6 irq after reset v1", {31'd0, irq}, 32'd0);
    check("R6 irq after reset v0", {31'd0, irq_v0}, 32'd0);
    rd_reg(0, 32'h1000_0000, 32'h0, "R6 R1 enable id");
    rd_reg(1, 32'h20, 32'h20, "R6 delay reset");
    rd_reg(2, 0, 0, "R6 fstat reset");
    rd_reg(4, 32'h07C0_0000, 32'h07C0_0000, "R6 faddr0 reset");
    rd_reg(5, 0, 0, "R6 faddr1 reset");
    rd_reg(8, 0, 0, "R6 evcnt1 reset");

    // R11 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    rd_reg(1, 32'h20, 32'h20, "R11 stalled read");
    for (int i = 0; i < 3; i++) begin
      check("R11 req_ready low while stalled", {31'd0, req_ready}, 32'd0);
      check("R11 data held", rsp_rdata, 32'h20);
      @(negedge clk);
    end
    rsp_ready = 1'b1;

    // R1 enable masking
    wr_reg(0, 32'hFFFF_FFFF);
    rd_reg(0, 32'h1000_0BFF, 32'h0000_0103, "R1 enable mask");
    // R2
    wr_reg(1, 32'hFFFF_FFFF);
    rd_reg(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R2 delay msb");
    // R4
    wr_reg(4, 32'h1234_5678);
    wr_reg(5, 32'h1234_5678);
    rd_reg(4, 32'h07C0_0000, 32'h07C0_0000, "R4 faddr0 ignores write");
    rd_reg(5, 0, 0, "R4 faddr1 ignores write");
    // R10
    wr_reg(7, 32'hA5A5_A5A5);
    wr_reg(8, 32'h5A5A_5A5A);
    wr_reg(12, 32'hFFFF_FFFF);
    rd_reg(7, 32'hA5A5_A5A5, 32'hA5A5_A5A5, "R10 evcnt0");
    rd_reg(8, 32'h5A5A_5A5A, 32'h5A5A_5A5A, "R10 evcnt1");
    rd_reg(12, 0, 0, "R10 unmapped offset");
    wr_reg(3, 32'h0BAD_F00D);
    wr_reg(6, 32'hCAFE_0001);
    rd_reg(3, 32'h0BAD_F00D, 32'h0BAD_F00D, "R10 video");
    rd_reg(6, 32'hCAFE_0001, 32'hCAFE_0001, "R10 diag word");

    // R12 non-word main access
    bus(1'b1, 1'b0, 1'b0, 6'd4, 32'h0000_5555);
    exp_q.push_back({32'h0, 32'h0}); tag_q.push_back("R12 non-word read zero");
    bus(1'b0, 1'b0, 1'b0, 6'd4, '0);
    rd_reg(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R12 non-word write ignored");

    // R8 inject, interrupts off
    wr_reg(0, 32'h1);
    inject(32'hFFFE_AB37, 1'b0, '0);
    check("R8 CE without IE v1", {31'd0, irq}, 32'd0);
    check("R8 CE without IE v0", {31'd0, irq_v0}, 32'd0);
    rd_reg(2, 32'h0000_AB31, 32'h0000_AB31, "R8 fstat fields");
    wr_reg(0, 32'h3);
    inject(32'h0000_0011, 1'b0, '0);
    check("R8 CE with IE v1", {31'd0, irq}, 32'd1);
    check("R8 CE with IE v0", {31'd0, irq_v0}, 32'd1);
    // R3
    wr_reg(2, 32'h0);
    check("R3 irq cleared", {31'd0, irq}, 32'd0);
    wr_reg(0, 32'h1);
    inject(32'h0001_0008, 1'b0, '0);
    check("R8 UE irq", {31'd0, irq}, 32'd1);
    wr_reg(2, 32'hDEAD_BEEF);
    check("R3 irq cleared after full write", {31'd0, irq_v0}, 32'd0);
    rd_reg(2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R3 fstat stores all bits");

    // R9 same-cycle inject and status write
    inject(32'h0000_0008, 1'b1, 32'h0);
    check("R9 irq from inject", {31'd0, irq}, 32'd1);
    rd_reg(2, 32'h8, 32'h8, "R9 inject record wins");
    wr_reg(2, 32'h0);
    inject(32'h0000_0001, 1'b1, 32'h0000_FFFF);
    check("R9 CE no IE keeps irq low", {31'd0, irq}, 32'd0);
    rd_reg(2, 32'h1, 32'h1, "R9 CE record wins");

    // R5 soft reset
    wr_reg(0, 32'hFFFF_FFFF);
    wr_reg(1, 32'h1234);
    wr_reg(7, 32'h7);
    inject(32'h8, 1'b0, '0);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check("R6 irq after soft reset", {31'd0, irq}, 32'd0);
    rd_reg(0, 32'h1000_0BFC, 32'h0000_0100, "R5 retained enable");
    rd_reg(1, 32'h20, 32'h20, "R6 delay after soft reset");
    rd_reg(2, 0, 0, "R6 fstat after soft reset");
    rd_reg(7, 0, 0, "R6 evcnt0 after soft reset");
    rd_reg(3, 0, 0, "R6 video after soft reset");
    rd_reg(4, 32'h07C0_0000, 32'h07C0_0000, "R6 faddr0 after soft reset");

    // R7 diagnostic byte window
    bus(1'b1, 1'b1, 1'b0, 6'd2, 32'hFFFF_FF5C);
    exp_q.push_back({32'h0, 32'h5C}); tag_q.push_back("R7 diag byte 2");
    bus(1'b0, 1'b1, 1'b0, 6'd2, '0);
    exp_q.push_back({32'h0, 32'h0}); tag_q.push_back("R7 diag byte 1 untouched");
    bus(1'b0, 1'b1, 1'b0, 6'd1, '0);

    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule